// File: doc/BRIEF.md
# Configuration Space Access Port

This block is the host side of a small configuration bus model. Software sees two 32-bit I/O ports. It writes a target selector into the address port, then reads or writes the data port. The selector holds an enable bit and a bus, device, function and dword register index. Data-port accesses go only to the target in the latched selector. The block also contains the register files of a few populated functions. Each function has a fixed identifier dword, a command register and an I/O-type base address register.

When the enable bit is clear, or when the selector names a function that does not exist, a data-port read returns all ones and a data-port write changes nothing. Each function's bus-master enable bit is brought out as a pin so that DMA logic can be gated on it. The low bits of the base address register cannot be written. Software can therefore size the window by writing all ones and reading the register back.

Populated function `i` sits on bus `BUS_NUM`, device `FIRST_DEV + i`, function 0. Its identifier is `{DEVICE_ID_BASE + i, VENDOR_ID}`.

Top module: `cfg_access_port`

## Requirements
- R1: Address port (I/O 0x0CF8) behaviour:
  - A write stores the 32-bit selector with bits 1:0 forced to zero.
  - A read of this port returns the stored selector.
  - The selector resets to 0.
  - Selector layout: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword index.
- R2: A read of the data port (I/O 0x0CFC) while selector bit 31 is 0 returns 0xFFFFFFFF.
- R3: Accesses to an absent target behave as follows:
  - A data-port read whose bus, device or function matches no populated function returns 0xFFFFFFFF.
  - A data-port write to such a target changes no register of any function.
- R4: Dword 0 (offset 0x00) of a populated function reads `{device_id, vendor_id}`. Writes to it are ignored.
- R5: Dword 1 (offset 0x04) is the command register:
  - Bits 2:0 are writable.
  - All other bits read 0.
  - It resets to 0.
- R6: `bus_master_en[i]` equals bit 2 of function i's command register. It changes in the cycle after the clock edge that takes the write.
- R7: Dword 4 (offset 0x10) is BAR0:
  - Bit 0 always reads 1, marking I/O space.
  - Bits BAR_BITS-1:1 always read 0.
  - Bits 31:BAR_BITS are writable and reset to 0.
  - With BAR_BITS = 8, writing 0xFFFFFFFF reads back 0xFFFFFF01.
- R8: Every other dword index of a populated function reads 0 and ignores writes.
- R9: Read timing and other ports:
  - A read raises `io_rvalid` for exactly one cycle after the edge that samples `io_rd`, with `io_rdata` valid in that cycle.
  - Reads of any I/O address other than the two ports return 0xFFFFFFFF.
- R10: A data-port write while selector bit 31 is 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid pulse |
| bus_master_en | output | NUM_FUNCS | Command bit 2 of each populated function |

## Verification
The bench reads the identifier dword of all 32 devices and 8 functions on the home bus, and of one device on another bus. A decoder that ignored the function or bus field would answer with a real identifier where all ones is expected. It writes through disabled selectors and to absent functions, then reads back the command registers and the bus-master pins. A design that did not gate writes on the enable bit or on the decoded target would show changed bits. BAR0 is sized with all ones and loaded with an address that has low bits set. A design that stored those bits, or lost the I/O type bit, would read back the wrong value.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam logic [15:0] ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;

  localparam logic [5:0] IDX_ID   = 6'd0;
  localparam logic [5:0] IDX_CMD  = 6'd1;
  localparam logic [5:0] IDX_BAR0 = 6'd4;

  localparam int CMD_W = 3;

  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] idx;
    logic [1:0] zero;
  } cfg_sel_t;

endpackage

// File: rtl/cfg_sel_latch.sv
module cfg_sel_latch
  import cfg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output cfg_sel_t    sel_q
);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_en) sel_q <= cfg_sel_t'(wdata & 32'hFFFF_FFFC);
  end

  AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (sel_q[31:2] == $past(wdata[31:2])) && (sel_q.zero == 2'b00)); // R1

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(sel_q)); // R1

endmodule

// File: rtl/cfg_func_regs.sv
module cfg_func_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h7100,
  parameter int          BAR_BITS  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [5:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        bus_master
);

  localparam int BAR_W = 32 - BAR_BITS;

  logic [CMD_W-1:0] cmd_q;
  logic [BAR_W-1:0] bar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      bar_q <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_CMD:  cmd_q <= wdata[CMD_W-1:0];
        IDX_BAR0: bar_q <= wdata[31:BAR_BITS];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_ID:   rdata = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:  rdata = {{(32-CMD_W){1'b0}}, cmd_q};
      IDX_BAR0: rdata = {bar_q, {(BAR_BITS-1){1'b0}}, 1'b1};
      default:  rdata = '0;
    endcase
  end

  assign bus_master = cmd_q[2];

  AST_BM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_CMD) |=> bus_master == $past(wdata[2])); // R6

  AST_BM_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == IDX_CMD) |=> $stable(bus_master)); // R6

  AST_BAR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == IDX_BAR0) |=> $stable(bar_q)); // R7

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter int          NUM_FUNCS      = 4,
  parameter logic [7:0]  BUS_NUM        = 8'd0,
  parameter int          FIRST_DEV      = 2,
  parameter logic [15:0] VENDOR_ID      = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID_BASE = 16'h7100,
  parameter int          BAR_BITS       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [31:0]          io_wdata,
  output logic [31:0]          io_rdata,
  output logic                 io_rvalid,
  output logic [NUM_FUNCS-1:0] bus_master_en
);

  cfg_sel_t             sel;
  logic                 sel_wr;
  logic                 data_wr;
  logic [NUM_FUNCS-1:0] hit;
  logic [31:0]          func_rdata [NUM_FUNCS];
  logic [31:0]          rd_next;

  assign sel_wr  = io_wr && (io_addr == ADDR_PORT);
  assign data_wr = io_wr && (io_addr == DATA_PORT) && sel.en;

  cfg_sel_latch u_sel (
    .clk   (clk),
    .rst   (rst),
    .wr_en (sel_wr),
    .wdata (io_wdata),
    .sel_q (sel)
  );

  for (genvar i = 0; i < NUM_FUNCS; i++) begin : g_func
    localparam logic [4:0]  DEV_SEL = 5'(FIRST_DEV + i);
    localparam logic [15:0] DEV_ID  = DEVICE_ID_BASE + 16'(i);

    assign hit[i] = (sel.bus == BUS_NUM) && (sel.dev == DEV_SEL) && (sel.func == 3'd0);

    cfg_func_regs #(
      .VENDOR_ID (VENDOR_ID),
      .DEVICE_ID (DEV_ID),
      .BAR_BITS  (BAR_BITS)
    ) u_regs (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (data_wr && hit[i]),
      .idx        (sel.idx),
      .wdata      (io_wdata),
      .rdata      (func_rdata[i]),
      .bus_master (bus_master_en[i])
    );
  end

  always_comb begin
    rd_next = '1;
    if (io_addr == ADDR_PORT) begin
      rd_next = sel;
    end else if (io_addr == DATA_PORT && sel.en) begin
      for (int i = 0; i < NUM_FUNCS; i++)
        if (hit[i]) rd_next = func_rdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) io_rdata <= rd_next;
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R3

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> io_rvalid); // R9

  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> !io_rvalid); // R9

  AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DATA_PORT && !sel.en) |=> io_rdata == 32'hFFFF_FFFF); // R2

  AST_MISS_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DATA_PORT && hit == '0) |=> io_rdata == 32'hFFFF_FFFF); // R3

  AST_BM_STILL_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == DATA_PORT && !sel.en) |=> $stable(bus_master_en)); // R10

endmodule

// File: tb/test_cfg_access_port.sv
module test_cfg_access_port;

  localparam int          NF     = 4;
  localparam int          FDEV   = 2;
  localparam logic [15:0] VEND   = 16'hA5C3;
  localparam logic [15:0] DEVB   = 16'h7100;
  localparam logic [15:0] APORT  = 16'h0CF8;
  localparam logic [15:0] DPORT  = 16'h0CFC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   io_addr = '0;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [31:0]   io_wdata = '0;
  logic [31:0]   io_rdata;
  logic          io_rvalid;
  logic [NF-1:0] bus_master_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cfg_access_port i_cfg_access_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .bus_master_en(bus_master_en)
  );

  function automatic logic [31:0] sel_val(bit en, int bus, int dev, int fn, int off);
    return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(off >> 2), 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
    if (io_rvalid !== 1'b1) begin
      n_chk++; n_bad++;
      $display("FAIL R9: actual rvalid %0b expected 1", io_rvalid);
    end
  endtask

  task automatic cfg_rd(bit en, int bus, int dev, int fn, int off, output logic [31:0] d);
    io_write(APORT, sel_val(en, bus, dev, fn, off));
    io_read(DPORT, d);
  endtask

  task automatic cfg_wr(bit en, int bus, int dev, int fn, int off, logic [31:0] v);
    io_write(APORT, sel_val(en, bus, dev, fn, off));
    io_write(DPORT, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    logic [NF-1:0] bm_exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R6 reset bus_master_en", 32'(bus_master_en), 32'd0);
    io_read(APORT, d);
    check("R1 reset selector", d, 32'd0);
    @(negedge clk);
    check("R9 rvalid single cycle", 32'(io_rvalid), 32'd0);

    // R1 selector capture, low bits forced to zero
    io_write(APORT, 32'h8012_3457);
    io_read(APORT, d);
    check("R1 selector readback", d, 32'h8012_3454);

    // R3/R4 sweep of identifier dwords on the home bus
    for (int dv = 0; dv < 32; dv++) begin
      for (int fn = 0; fn < 8; fn++) begin
        cfg_rd(1'b1, 0, dv, fn, 0, d);
        if (fn == 0 && dv >= FDEV && dv < FDEV + NF)
          exp = {DEVB + 16'(dv - FDEV), VEND};
        else
          exp = 32'hFFFF_FFFF;
        check("R3/R4 id sweep", d, exp);
      end
    end
    cfg_rd(1'b1, 1, FDEV, 0, 0, d);
    check("R3 other bus", d, 32'hFFFF_FFFF);

    // R2 enable clear
    cfg_rd(1'b0, 0, FDEV, 0, 0, d);
    check("R2 disabled read", d, 32'hFFFF_FFFF);

    // R5 command register, R6 bus master pins
    cfg_rd(1'b1, 0, FDEV + 1, 0, 4, d);
    check("R5 cmd reset", d, 32'd0);
    bm_exp = '0;
    for (int k = 0; k < NF; k++) begin
      cfg_wr(1'b1, 0, FDEV + k, 0, 4, 32'hFFFF_FFFF);
      bm_exp[k] = 1'b1;
      check("R6 bus master set", 32'(bus_master_en), 32'(bm_exp));
      cfg_rd(1'b1, 0, FDEV + k, 0, 4, d);
      check("R5 cmd mask", d, 32'h0000_0007);
    end
    cfg_wr(1'b1, 0, FDEV + 2, 0, 4, 32'h0000_0003);
    bm_exp[2] = 1'b0;
    check("R6 bus master clear", 32'(bus_master_en), 32'(bm_exp));
    cfg_rd(1'b1, 0, FDEV + 2, 0, 4, d);
    check("R5 cmd partial", d, 32'h0000_0003);

    // R10 disabled write ignored
    cfg_wr(1'b0, 0, FDEV + 2, 0, 4, 32'h0000_0004);
    check("R10 pins after disabled write", 32'(bus_master_en), 32'(bm_exp));
    cfg_rd(1'b1, 0, FDEV + 2, 0, 4, d);
    check("R10 cmd after disabled write", d, 32'h0000_0003);

    // R3 write to absent function ignored
    cfg_wr(1'b1, 0, FDEV + 2, 1, 4, 32'h0000_0004);
    cfg_wr(1'b1, 3, FDEV + 2, 0, 4, 32'h0000_0004);
    check("R3 pins after absent write", 32'(bus_master_en), 32'(bm_exp));
    cfg_rd(1'b1, 0, FDEV + 2, 0, 4, d);
    check("R3 cmd after absent write", d, 32'h0000_0003);

    // R4 identifier write ignored
    cfg_wr(1'b1, 0, FDEV, 0, 0, 32'h1234_5678);
    cfg_rd(1'b1, 0, FDEV, 0, 0, d);
    check("R4 id after write", d, {DEVB, VEND});

    // R7 BAR0 type and sizing
    cfg_rd(1'b1, 0, FDEV + 3, 0, 16, d);
    check("R7 bar reset", d, 32'h0000_0001);
    cfg_wr(1'b1, 0, FDEV + 3, 0, 16, 32'hFFFF_FFFF);
    cfg_rd(1'b1, 0, FDEV + 3, 0, 16, d);
    check("R7 bar sizing", d, 32'hFFFF_FF01);
    cfg_wr(1'b1, 0, FDEV + 3, 0, 16, 32'h0000_C0FE);
    cfg_rd(1'b1, 0, FDEV + 3, 0, 16, d);
    check("R7 bar base", d, 32'h0000_C001);
    cfg_rd(1'b1, 0, FDEV + 1, 0, 16, d);
    check("R7 bar neighbour untouched", d, 32'h0000_0001);

    // R8 other dwords
    cfg_wr(1'b1, 0, FDEV, 0, 8, 32'hDEAD_BEEF);
    cfg_rd(1'b1, 0, FDEV, 0, 8, d);
    check("R8 dword 2", d, 32'd0);
    cfg_rd(1'b1, 0, FDEV, 0, 60, d);
    check("R8 dword 15", d, 32'd0);

    // R9 unrelated I/O address
    io_read(16'h0080, d);
    check("R9 other port", d, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule